// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block joins a bus master that makes 8-, 16- and 32-bit accesses to a register file whose registers each have a fixed native width of one, two or four bytes. The adapter keeps the master unaware of those widths. It masks the offset, looks up the native width of the addressed 4-byte group, and then picks one of four treatments. An access of the native width passes straight through. A narrower read takes its lanes from the enclosing register. A narrower write becomes a read-modify-write. A wider access is broken into a series of native-width accesses. All lane placement is big-endian: the lowest byte address carries the most significant byte.

One bus access can take up to four register-file accesses. A small sequencer therefore raises `busy` while it works and pulses `done` with the read data and an error flag. The register file reads with one cycle of latency, as a block RAM does. Register-file addresses are always aligned to the native width.

Top module: `wacc_adapter`

## Requirements
- R1: Only the low 10 bits of `req_addr` are used; higher bits have no effect.
- R2: A masked offset of 0x200 or above, or a `req_size` of 3, completes with `err`=1, `rdata`=0 and no register-file write.
- R3: The native-width map uses offset bits 8:6. Regions 0 and 6 are byte registers, regions 1 and 4 are halfword registers, and regions 2 and 5 are word registers. Regions 3 and 7 are unimplemented and complete with `err`=1, `rdata`=0 and no write.
- R4: An access whose size (0 byte, 1 halfword, 2 word) equals the native width makes exactly one register-file access at that offset.
- R5: A read narrower than the register returns the addressed lanes of the enclosing register, big-endian. For example, the odd byte of a halfword is its low byte.
- R6: A write narrower than the register reads the enclosing register and then writes it back with only the addressed bytes replaced.
- R7: A read wider than the register is assembled from consecutive native reads, with the lowest address in the most significant position.
- R8: A write wider than the register is issued as consecutive native writes. The most significant part goes to the lowest address, and that write comes first.
- R9: Address bits below the access size are ignored, so every access is treated as naturally aligned.
- R10: `busy` is high while a request is in progress, and `req_valid` pulses during that time are ignored. The `done` edge count from the accepting edge is fixed: an error takes 1; a read takes 1+2k for k native beats; a write takes 1+k; a narrow read takes 3; a narrow write takes 4.
- R11: After reset, `busy`, `done`, `err`, `rdata` and `rf_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request pulse, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | IN_AW | Byte offset of the access |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion had an illegal offset, size or region |
| rdata | output | 32 | Read result, right-justified; 0 for writes and errors |
| rf_en | output | 1 | Register-file access strobe |
| rf_we | output | 1 | Register-file write |
| rf_size | output | 2 | Native width code of the access |
| rf_addr | output | BASE_W | Register-file byte offset, aligned to native width |
| rf_wdata | output | 32 | Register-file write data, right-justified |
| rf_rdata | input | 32 | Register-file read data, valid one cycle after a read strobe |

## Verification
Each result is due a fixed number of rising edges after the accepting edge, and that number depends only on the error status, the direction and the ratio of access size to native width. The number is 1 for errors, 2 plus the extra write beats for writes, and 1 plus two per beat for reads. The driver counts edges from the accepting edge to the first falling edge where `done` is seen and compares that count with the formula. A separate monitor compares the data and the error flag at that same falling edge against a byte-level reference memory. All outputs are sampled on falling edges, half a period away from the edges where they change.

// File: rtl/wacc_pkg.sv
package wacc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_CAPT  = 2'd2
  } wacc_state_e;

  // Native width code per region: 0 none, otherwise log2(bytes)+1.
  function automatic logic [1:0] region_code(input logic [2:0] region);
    logic [1:0] c;
    case (region)
      3'd0, 3'd6: c = 2'd1;
      3'd1, 3'd4: c = 2'd2;
      3'd2, 3'd5: c = 2'd3;
      default:    c = 2'd0;
    endcase
    return c;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] lg);
    logic [31:0] m;
    case (lg)
      2'd0:    m = 32'h0000_00FF;
      2'd1:    m = 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/wacc_decode.sv
module wacc_decode import wacc_pkg::*; #(
  parameter int IN_AW  = 32,
  parameter int OFF_W  = 10,
  parameter int SPACE  = 512,
  parameter int BASE_W = 9
) (
  input  logic [IN_AW-1:0]  addr,
  input  logic [1:0]        size,
  output logic [BASE_W-1:0] base,
  output logic [1:0]        nat_lg,
  output logic              bad
);
  logic [OFF_W-1:0] low_m;
  logic [OFF_W-1:0] off;
  logic [1:0]       code;

  always_comb begin
    case (size)
      2'd1:    low_m = OFF_W'(1);
      2'd2:    low_m = OFF_W'(3);
      default: low_m = '0;
    endcase
    off    = addr[OFF_W-1:0] & ~low_m;
    code   = region_code(off[BASE_W-1 -: 3]);
    base   = off[BASE_W-1:0];
    nat_lg = code - 2'd1;
    bad    = (int'(off) >= SPACE) || (size == 2'd3) || (code == 2'd0);
  end
endmodule

// File: rtl/wacc_lane.sv
module wacc_lane import wacc_pkg::*; (
  input  logic [31:0] nat_data,
  input  logic [1:0]  nat_lg,
  input  logic [1:0]  req_lg,
  input  logic [1:0]  byte_off,
  input  logic [31:0] new_data,
  output logic [31:0] extract,
  output logic [31:0] merged
);
  logic [2:0]  nbytes;
  logic [2:0]  rbytes;
  logic [4:0]  sh;
  logic [31:0] rmask;
  logic [31:0] place;

  always_comb begin
    nbytes  = 3'd1 << nat_lg;
    rbytes  = 3'd1 << req_lg;
    sh      = {2'b00, nbytes - rbytes - {1'b0, byte_off}} << 3;
    rmask   = lane_mask(req_lg);
    extract = (nat_data >> sh) & rmask;
    place   = rmask << sh;
    merged  = (nat_data & ~place) | ((new_data & rmask) << sh);
  end
endmodule

// File: rtl/wacc_seq.sv
module wacc_seq import wacc_pkg::*; #(
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [BASE_W-1:0] dec_base,
  input  logic [1:0]        dec_nat_lg,
  input  logic              dec_bad,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic              rf_en,
  output logic              rf_we,
  output logic [1:0]        rf_size,
  output logic [BASE_W-1:0] rf_addr,
  output logic [31:0]       rf_wdata,
  input  logic [31:0]       rf_rdata
);
  wacc_state_e       st;
  logic              wr_q, narrow_q, done_q, err_q;
  logic [1:0]        req_lg_q, nat_lg_q, beat_q, last_q;
  logic [BASE_W-1:0] base_q;
  logic [31:0]       acc_q, wdat_q, rdata_q;

  logic [BASE_W-1:0] nat_lo;
  logic [4:0]        piece_sh;
  logic [5:0]        acc_sh;
  logic [31:0]       piece, cap_data, gathered, ext, mrg;

  always_comb begin
    nat_lo   = BASE_W'((1 << nat_lg_q) - 1);
    rf_en    = (st == ST_ISSUE);
    rf_we    = rf_en && wr_q && (!narrow_q || beat_q[0]);
    rf_size  = nat_lg_q;
    rf_addr  = narrow_q ? (base_q & ~nat_lo)
                        : base_q + (BASE_W'(beat_q) << nat_lg_q);
    piece_sh = {2'((last_q - beat_q) << nat_lg_q), 3'b000};
    piece    = (wdat_q >> piece_sh) & lane_mask(nat_lg_q);
    rf_wdata = narrow_q ? acc_q : piece;
    cap_data = rf_rdata & lane_mask(nat_lg_q);
    acc_sh   = 6'd8 << nat_lg_q;
    gathered = (nat_lg_q == 2'd2) ? cap_data : ((acc_q << acc_sh) | cap_data);
  end

  wacc_lane u_lane (
    .nat_data (cap_data),
    .nat_lg   (nat_lg_q),
    .req_lg   (req_lg_q),
    .byte_off (base_q[1:0] & nat_lo[1:0]),
    .new_data (wdat_q),
    .extract  (ext),
    .merged   (mrg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      wr_q     <= 1'b0;
      narrow_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      req_lg_q <= '0;
      nat_lg_q <= '0;
      beat_q   <= '0;
      last_q   <= '0;
      base_q   <= '0;
      acc_q    <= '0;
      wdat_q   <= '0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          wr_q     <= req_write;
          wdat_q   <= req_wdata;
          base_q   <= dec_base;
          req_lg_q <= req_size;
          nat_lg_q <= dec_nat_lg;
          narrow_q <= req_size < dec_nat_lg;
          beat_q   <= '0;
          acc_q    <= '0;
          if (req_size > dec_nat_lg)
            last_q <= ((req_size - dec_nat_lg) == 2'd1) ? 2'd1 : 2'd3;
          else
            last_q <= 2'd0;
          if (dec_bad) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            rdata_q <= '0;
          end else begin
            st <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (rf_we) begin
            if (narrow_q || beat_q == last_q) begin
              st      <= ST_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b0;
              rdata_q <= '0;
            end else begin
              beat_q <= beat_q + 2'd1;
            end
          end else begin
            st <= ST_CAPT;
          end
        end
        ST_CAPT: begin
          if (narrow_q) begin
            if (wr_q) begin
              acc_q  <= mrg;
              beat_q <= 2'd1;
              st     <= ST_ISSUE;
            end else begin
              rdata_q <= ext;
              err_q   <= 1'b0;
              done_q  <= 1'b1;
              st      <= ST_IDLE;
            end
          end else if (beat_q == last_q) begin
            rdata_q <= gathered;
            err_q   <= 1'b0;
            done_q  <= 1'b1;
            st      <= ST_IDLE;
          end else begin
            acc_q  <= gathered;
            beat_q <= beat_q + 2'd1;
            st     <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (st != ST_IDLE);
  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;

  assert_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_rf_align_R9: assert property (@(posedge clk) disable iff (rst)
    rf_en |-> ((rf_addr & nat_lo) == '0));
  assert_err_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rdata == '0));
  assert_rmw_order_R6: assert property (@(posedge clk) disable iff (rst)
    (rf_we && narrow_q) |-> ($past(st) == ST_CAPT));
endmodule

// File: rtl/wacc_adapter.sv
module wacc_adapter import wacc_pkg::*; #(
  parameter int IN_AW  = 32,
  parameter int OFF_W  = 10,
  parameter int SPACE  = 512,
  parameter int BASE_W = $clog2(SPACE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [IN_AW-1:0]  req_addr,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic              rf_en,
  output logic              rf_we,
  output logic [1:0]        rf_size,
  output logic [BASE_W-1:0] rf_addr,
  output logic [31:0]       rf_wdata,
  input  logic [31:0]       rf_rdata
);
  logic [BASE_W-1:0] dec_base;
  logic [1:0]        dec_nat_lg;
  logic              dec_bad;

  wacc_decode #(
    .IN_AW(IN_AW), .OFF_W(OFF_W), .SPACE(SPACE), .BASE_W(BASE_W)
  ) u_decode (
    .addr   (req_addr),
    .size   (req_size),
    .base   (dec_base),
    .nat_lg (dec_nat_lg),
    .bad    (dec_bad)
  );

  wacc_seq #(.BASE_W(BASE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .dec_base   (dec_base),
    .dec_nat_lg (dec_nat_lg),
    .dec_bad    (dec_bad),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .rdata      (rdata),
    .rf_en      (rf_en),
    .rf_we      (rf_we),
    .rf_size    (rf_size),
    .rf_addr    (rf_addr),
    .rf_wdata   (rf_wdata),
    .rf_rdata   (rf_rdata)
  );
endmodule

// File: tb/test_wacc_adapter.sv
module test_wacc_adapter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        busy, done, err, rf_en, rf_we;
  logic [31:0] rdata, rf_wdata, rf_rdata;
  logic [1:0]  rf_size;
  logic [8:0]  rf_addr;

  always #5 clk = ~clk;

  wacc_adapter i_wacc_adapter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .rf_en(rf_en), .rf_we(rf_we), .rf_size(rf_size), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  int n_checks = 0, n_err = 0, cyc = 0;
  bit timed_out = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Register-file model: byte storage, big-endian, one-cycle read latency.
  logic [7:0]  mem [0:511];
  logic [7:0]  shadow [0:511];
  logic [31:0] rdq;
  bit          wr_seen;
  logic [8:0]  first_wa;
  assign rf_rdata = rdq;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 37 + 5);
      rdq <= '0;
    end else if (rf_en) begin
      if (rf_we) begin
        for (int i = 0; i < (1 << rf_size); i++)
          mem[rf_addr + 9'(i)] <= rf_wdata[8*((1 << rf_size) - 1 - i) +: 8];
        if (!wr_seen) first_wa = rf_addr;
        wr_seen = 1;
      end else begin
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < (1 << rf_size); i++) v = (v << 8) | 32'(mem[rf_addr + 9'(i)]);
        rdq <= v;
      end
    end
  end

  typedef struct { logic [31:0] rd; bit er; string tag; } sb_item_t;
  sb_item_t sb[$];

  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        check(0, "R10", "unexpected done", 32'd1, 32'd0);
      end else begin
        sb_item_t it;
        it = sb.pop_front();
        check(rdata == it.rd, it.tag, "rdata", rdata, it.rd);
        check(err == it.er, it.tag, "err", 32'(err), 32'(it.er));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !timed_out) begin
      timed_out = 1;
      n_checks++;
      n_err++;
      $display("FAIL R10 watchdog: actual %0d expected below 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  function automatic int code_of(input int off);
    case ((off >> 6) & 7)
      0, 6: return 1;
      1, 4: return 2;
      2, 5: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic issue(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                       input logic [31:0] wd, input string rq, input bit inject);
    sb_item_t it;
    int nb, aoff, nl, d, lat, exp_lat;
    bit bad;
    logic [31:0] v;
    nb = 1 << sz;
    aoff = int'(addr[9:0]) & ~(nb - 1);
    bad = (sz == 2'd3) || (aoff >= 512);
    if (!bad) bad = (code_of(aoff) == 0);
    it.er = bad; it.rd = '0; it.tag = rq;
    nl = 0;
    if (!bad) begin
      nl = code_of(aoff) - 1;
      if (!wr) begin
        v = '0;
        for (int i = 0; i < nb; i++) v = (v << 8) | 32'(shadow[aoff + i]);
        it.rd = v;
      end else begin
        for (int i = 0; i < nb; i++) shadow[aoff + i] = wd[8*(nb - 1 - i) +: 8];
      end
    end
    d = int'(sz) - nl;
    if (bad)        exp_lat = 1;
    else if (d == 0) exp_lat = wr ? 2 : 3;
    else if (d < 0)  exp_lat = wr ? 4 : 3;
    else             exp_lat = wr ? 1 + (1 << d) : 1 + 2 * (1 << d);
    sb.push_back(it);
    @(negedge clk);
    wr_seen = 0;
    req_valid = 1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    req_valid = 0;
    while (!done && !timed_out) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (inject && lat == 2) begin
        req_valid = 1; req_write = 1; req_size = 2'd0;
        req_addr = 32'h30; req_wdata = 32'h5A;
      end else begin
        req_valid = 0;
      end
    end
    req_valid = 0;
    check(lat == exp_lat, "R10", {rq, " latency"}, 32'(lat), 32'(exp_lat));
    if (bad)
      check(!wr_seen, rq, "no write on error", 32'(wr_seen), 32'd0);
    else if (wr)
      check(wr_seen && int'(first_wa) == (aoff & ~((1 << nl) - 1)), rq,
            "first write address", 32'(first_wa), 32'(aoff & ~((1 << nl) - 1)));
  endtask

  initial begin
    for (int i = 0; i < 512; i++) shadow[i] = 8'(i * 37 + 5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !done && !err && !rf_en && rdata == 0, "R11", "reset state",
          {busy, done, err, rf_en, 28'(rdata)}, 32'd0);
    // same width
    issue(0, 2'd0, 32'h005, 0, "R4", 0);
    issue(0, 2'd1, 32'h046, 0, "R4", 0);
    issue(0, 2'd2, 32'h088, 0, "R4", 0);
    issue(1, 2'd2, 32'h08C, 32'hCAFE_F00D, "R4", 0);
    issue(0, 2'd2, 32'h08C, 0, "R4", 0);
    // narrow reads
    issue(0, 2'd0, 32'h043, 0, "R5", 0);
    issue(0, 2'd0, 32'h042, 0, "R5", 0);
    issue(0, 2'd0, 32'h141, 0, "R5", 0);
    issue(0, 2'd0, 32'h143, 0, "R5", 0);
    issue(0, 2'd1, 32'h082, 0, "R5", 0);
    issue(0, 2'd1, 32'h080, 0, "R5", 0);
    // narrow writes
    issue(1, 2'd0, 32'h045, 32'hA5, "R6", 0);
    issue(0, 2'd1, 32'h044, 0, "R6", 0);
    issue(1, 2'd1, 32'h14A, 32'h1234, "R6", 0);
    issue(1, 2'd0, 32'h142, 32'h77, "R6", 0);
    issue(0, 2'd2, 32'h148, 0, "R6", 0);
    issue(0, 2'd2, 32'h140, 0, "R6", 0);
    // wide reads and writes
    issue(0, 2'd2, 32'h010, 0, "R7", 0);
    issue(0, 2'd1, 32'h182, 0, "R7", 0);
    issue(0, 2'd2, 32'h104, 0, "R7", 0);
    issue(1, 2'd2, 32'h020, 32'h0102_0304, "R8", 0);
    issue(0, 2'd0, 32'h020, 0, "R8", 0);
    issue(0, 2'd0, 32'h023, 0, "R8", 0);
    issue(1, 2'd1, 32'h184, 32'hBEEF, "R8", 0);
    issue(0, 2'd0, 32'h184, 0, "R8", 0);
    issue(1, 2'd2, 32'h108, 32'hDEAD_BEEF, "R8", 0);
    issue(0, 2'd1, 32'h108, 0, "R8", 0);
    // errors
    issue(0, 2'd0, 32'h200, 0, "R2", 0);
    issue(1, 2'd1, 32'h3FE, 32'hFFFF, "R2", 0);
    issue(1, 2'd3, 32'h010, 32'h1, "R2", 0);
    issue(1, 2'd2, 32'h0C4, 32'h5555_5555, "R3", 0);
    issue(0, 2'd0, 32'h1C0, 0, "R3", 0);
    // masking and alignment
    issue(0, 2'd0, 32'h405, 0, "R1", 0);
    issue(1, 2'd1, 32'hC48, 32'h6789, "R1", 0);
    issue(0, 2'd1, 32'h048, 0, "R1", 0);
    issue(0, 2'd1, 32'h047, 0, "R9", 0);
    issue(1, 2'd2, 32'h089, 32'h1122_3344, "R9", 0);
    issue(0, 2'd2, 32'h088, 0, "R9", 0);
    // request while busy is ignored
    issue(0, 2'd2, 32'h010, 0, "R10", 1);
    issue(0, 2'd0, 32'h030, 0, "R10", 0);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R10", "all completions seen", 32'(sb.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule